// File: doc/BRIEF.md
# Packed Even-Lane Widening Multiplier

This block takes two 128-bit operand vectors, each seen as four 32-bit lanes with lane 0 in the least significant bits. It multiplies lane 0 of one operand by lane 0 of the other, and lane 2 by lane 2. Both products are unsigned and kept at their full 64-bit width. The two products are packed into a single 128-bit result. Lanes 1 and 3 of either operand play no part in the result.

Operands enter and results leave through valid/ready handshakes. The multiply is spread over a pipeline whose depth `LAT` is a parameter (at least 1). When the output is not stalled, the block accepts one operand pair per cycle. When the consumer stalls, empty stages still fill, so back-pressure reaches the input only once every stage holds a pair.

Top module: `pemul_top`

## Requirements
- R1: Bits 63:0 of the result are the product of operand A bits 31:0 and operand B bits 31:0.
- R2: Bits 127:64 of the result are the product of operand A bits 95:64 and operand B bits 95:64.
- R3: Both products are unsigned and exact over 64 bits; all-ones times all-ones gives 0xFFFFFFFE00000001.
- R4: Bits 63:32 and 127:96 of either operand have no effect on the result.
- R5: A pair is taken when in_valid and in_ready are both high, and results leave in the order pairs were taken.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R7: With out_ready held high, a result appears on out_valid exactly LAT cycles after its pair is taken.
- R8: Whenever out_ready is high, in_ready is high, so one pair per cycle can be taken.
- R9: An asserted reset empties the pipeline: out_valid goes low and in_ready goes high.
- R10: With out_ready held low from an empty state, exactly LAT pairs are taken before in_ready drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operand pair is presented |
| in_ready | output | 1 | The block can take a pair this cycle |
| in_a | input | 128 | Operand A, four 32-bit lanes |
| in_b | input | 128 | Operand B, four 32-bit lanes |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_data | output | 128 | Lane-2 product in the upper half, lane-0 product in the lower half |

## Verification
The hardest state to reach is a pipeline where every stage is full and the output is stalled. In that state the ready chain has to block the input, yet the held result must not move. To reach it, the stimulus keeps out_ready low and offers a new pair every cycle from an empty pipeline. It counts how many pairs are taken before in_ready falls, and watches out_data across several stalled cycles. It then drains the pipeline and checks the order of the results. A reset is also applied while the pipeline is full, to show that all valid state is cleared.

// File: rtl/pemul_pkg.sv
package pemul_pkg;
  localparam int unsigned DEF_LANE_W = 32;
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_LAT    = 3;
endpackage

// File: rtl/pemul_split.sv
module pemul_split #(
  parameter int unsigned LW = pemul_pkg::DEF_LANE_W
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  output logic [LW-1:0] pp_ll,
  output logic [LW-1:0] pp_lh,
  output logic [LW-1:0] pp_hl,
  output logic [LW-1:0] pp_hh
);
  localparam int unsigned H = LW / 2;

  logic [LW-1:0] a_lo, a_hi, b_lo, b_hi;

  always_comb begin
    a_lo = LW'(a[H-1:0]);
    a_hi = LW'(a[LW-1:H]);
    b_lo = LW'(b[H-1:0]);
    b_hi = LW'(b[LW-1:H]);
    pp_ll = a_lo * b_lo;
    pp_lh = a_lo * b_hi;
    pp_hl = a_hi * b_lo;
    pp_hh = a_hi * b_hi;
  end
endmodule

// File: rtl/pemul_combine.sv
module pemul_combine #(
  parameter int unsigned LW = pemul_pkg::DEF_LANE_W
) (
  input  logic [LW-1:0]   pp_ll,
  input  logic [LW-1:0]   pp_lh,
  input  logic [LW-1:0]   pp_hl,
  input  logic [LW-1:0]   pp_hh,
  output logic [2*LW-1:0] prod
);
  localparam int unsigned H  = LW / 2;
  localparam int unsigned PW = 2 * LW;

  logic [LW:0]   mid;
  logic [PW-1:0] mid_sh;

  always_comb begin
    mid    = {1'b0, pp_lh} + {1'b0, pp_hl};
    mid_sh = {{(LW-H-1){1'b0}}, mid, {H{1'b0}}};
    prod   = {pp_hh, pp_ll} + mid_sh;
  end
endmodule

// File: rtl/pemul_flow.sv
module pemul_flow #(
  parameter int unsigned LAT = pemul_pkg::DEF_LAT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [LAT-1:0] stg_load
);
  localparam int unsigned CW = $clog2(LAT + 2);

  logic [LAT-1:0] vld_q, vld_d;
  logic [LAT:0]   rdy;

  always_comb begin
    rdy[LAT] = out_ready;
    for (int i = LAT - 1; i >= 0; i--) begin
      rdy[i] = !vld_q[i] || rdy[i+1];
    end
  end

  always_comb begin
    vld_d[0]    = rdy[0] ? in_valid : vld_q[0];
    stg_load[0] = rdy[0] && in_valid;
    for (int i = 1; i < LAT; i++) begin
      vld_d[i]    = rdy[i] ? vld_q[i-1] : vld_q[i];
      stg_load[i] = rdy[i] && vld_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign in_ready  = rdy[0];
  assign out_valid = vld_q[LAT-1];

  // occupancy tracked from the port handshakes, compared with stage flags
  logic [CW-1:0] occ_q, occ_d;

  always_comb begin
    occ_d = occ_q;
    if (in_valid && in_ready)   occ_d = occ_d + 1'b1;
    if (out_valid && out_ready) occ_d = occ_d - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  assert_occupancy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_q) == $countones(vld_q));

  assert_hold_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_full_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  assert_full_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ_q) == LAT) && !out_ready |-> !in_ready);
endmodule

// File: rtl/pemul_top.sv
module pemul_top #(
  parameter int unsigned LW    = pemul_pkg::DEF_LANE_W,
  parameter int unsigned LANES = pemul_pkg::DEF_LANES,
  parameter int unsigned LAT   = pemul_pkg::DEF_LAT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LW*LANES-1:0] in_a,
  input  logic [LW*LANES-1:0] in_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LW*LANES-1:0] out_data
);
  localparam int unsigned PW = 2 * LW;
  localparam int unsigned NE = LANES / 2;

  logic [LAT-1:0] stg_load;

  pemul_flow #(.LAT(LAT)) u_flow (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .stg_load (stg_load)
  );

  logic [NE-1:0] odd_bits;

  for (genvar j = 0; j < NE; j++) begin : g_lane
    logic [LW-1:0] op_a, op_b;
    logic [LW-1:0] sp_ll, sp_lh, sp_hl, sp_hh;
    logic [PW-1:0] lane_res;

    assign op_a        = in_a[2*j*LW +: LW];
    assign op_b        = in_b[2*j*LW +: LW];
    assign odd_bits[j] = ^{in_a[(2*j+1)*LW +: LW], in_b[(2*j+1)*LW +: LW]};

    pemul_split #(.LW(LW)) u_split (
      .a(op_a), .b(op_b),
      .pp_ll(sp_ll), .pp_lh(sp_lh), .pp_hl(sp_hl), .pp_hh(sp_hh)
    );

    if (LAT == 1) begin : g_one
      logic [PW-1:0] prod_d, prod_q;

      pemul_combine #(.LW(LW)) u_comb (
        .pp_ll(sp_ll), .pp_lh(sp_lh), .pp_hl(sp_hl), .pp_hh(sp_hh),
        .prod(prod_d)
      );

      always_ff @(posedge clk) begin
        if (stg_load[0]) prod_q <= prod_d;
      end

      assign lane_res = prod_q;
    end else begin : g_multi
      logic [LW-1:0] pq_ll, pq_lh, pq_hl, pq_hh;
      logic [PW-1:0] comb_d;
      logic [PW-1:0] pipe_q [1:LAT-1];

      always_ff @(posedge clk) begin
        if (stg_load[0]) begin
          pq_ll <= sp_ll;
          pq_lh <= sp_lh;
          pq_hl <= sp_hl;
          pq_hh <= sp_hh;
        end
      end

      pemul_combine #(.LW(LW)) u_comb (
        .pp_ll(pq_ll), .pp_lh(pq_lh), .pp_hl(pq_hl), .pp_hh(pq_hh),
        .prod(comb_d)
      );

      always_ff @(posedge clk) begin
        if (stg_load[1]) pipe_q[1] <= comb_d;
      end

      for (genvar k = 2; k < LAT; k++) begin : g_dly
        always_ff @(posedge clk) begin
          if (stg_load[k]) pipe_q[k] <= pipe_q[k-1];
        end
      end

      assign lane_res = pipe_q[LAT-1];
    end

    assign out_data[j*PW +: PW] = lane_res;
  end

  logic unused_odd_lanes;
  assign unused_odd_lanes = ^odd_bits;

  assert_hold_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));
endmodule

// File: tb/pemul_top_bench.sv
module pemul_top_bench;
  localparam int LAT = 3;
  localparam int NV  = 6;

  logic         clk;
  logic         rst_n;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [127:0] in_a, in_b, out_data;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 0;

  pemul_top #(.LW(32), .LANES(4), .LAT(LAT)) u_pemul_top (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [127:0] VA [NV] = '{
    {32'hDEADBEEF, 32'd5,        32'hCAFEF00D, 32'd2},
    {32'h00000001, 32'h0,        32'h00000077, 32'hFFFFFFFF},
    {32'h00000000, 32'h80000000, 32'hFFFFFFFF, 32'h00010000},
    {32'h00000005, 32'h00010000, 32'h00000006, 32'hFFFFFFFF},
    {32'hAAAAAAAA, 32'hFFFFFFFF, 32'h55555555, 32'h12345678},
    {32'h00000000, 32'h80000000, 32'h00000000, 32'h0000FFFF}};
  localparam logic [127:0] VB [NV] = '{
    {32'h12345678, 32'd7,        32'h9ABCDEF0, 32'd3},
    {32'h00000002, 32'h12345678, 32'h00000088, 32'hFFFFFFFF},
    {32'hFFFFFFFF, 32'h00000002, 32'h00000000, 32'h00010000},
    {32'h00000007, 32'h0000FFFF, 32'h00000008, 32'h00000001},
    {32'h55555555, 32'hFFFFFFFF, 32'hAAAAAAAA, 32'h00000010},
    {32'h00000000, 32'h80000000, 32'h00000000, 32'h0000FFFF}};
  localparam logic [63:0] VLO [NV] = '{
    64'd6, 64'hFFFFFFFE00000001, 64'h100000000,
    64'hFFFFFFFF, 64'h123456780, 64'hFFFE0001};
  localparam logic [63:0] VHI [NV] = '{
    64'd35, 64'd0, 64'h100000000,
    64'hFFFF0000, 64'hFFFFFFFE00000001, 64'h4000000000000000};

  function automatic logic [127:0] ref_mul(logic [127:0] a, logic [127:0] b);
    logic [63:0] lo, hi;
    lo = 64'(a[31:0])  * 64'(b[31:0]);
    hi = 64'(a[95:64]) * 64'(b[95:64]);
    return {hi, lo};
  endfunction

  function automatic logic [127:0] gen_op(int i, int s);
    return {32'(i * 32'h01010101 + s), 32'(32'h9E3779B9 * (i + 1) + s),
            32'(32'h7F4A7C15 ^ (i * 77)), 32'(32'hFFFFFFFF - i * 3 - s)};
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  endtask

  // one pair through an idle pipeline; returns result and measured latency
  task automatic xfer(logic [127:0] a, logic [127:0] b,
                      output logic [127:0] res, output int lat);
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    res = out_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [127:0] res;
    int lat;
    int acc;
    int rcv;
    logic [127:0] held;

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", 128'(out_valid), 128'd0);
    chk("R9 reset in_ready",  128'(in_ready),  128'd1);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R7
    for (int v = 0; v < NV; v++) begin
      xfer(VA[v], VB[v], res, lat);
      chk("R1 lane0 product", 128'(res[63:0]),   128'(VLO[v]));
      chk("R2 lane2 product", 128'(res[127:64]), 128'(VHI[v]));
      chk("R3 reference",     res, ref_mul(VA[v], VB[v]));
      chk("R7 latency",       128'(lat), 128'(LAT));
    end

    // R4: odd lanes flipped, result unchanged
    xfer(VA[0] ^ {32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'h0},
         VB[0] ^ {32'h0F0F0F0F, 32'h0, 32'hF0F0F0F0, 32'h0}, res, lat);
    chk("R4 odd lanes ignored", res, {VHI[0], VLO[0]});

    // R3 corner: all-ones on both even lanes
    xfer({32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF},
         {32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF}, res, lat);
    chk("R3 all-ones", res, {64'hFFFFFFFE00000001, 64'hFFFFFFFE00000001});

    // streaming: R5 R7 R8
    @(negedge clk);
    out_ready = 1'b1;
    rcv = 0;
    for (int n = 0; n < 8 + LAT + 2; n++) begin
      if (out_valid) begin
        chk("R5 stream order", out_data, ref_mul(gen_op(rcv, 1), gen_op(rcv, 2)));
        chk("R7 stream latency", 128'(n), 128'(rcv + LAT));
        rcv++;
      end
      if (n < 8) begin
        chk("R8 in_ready while draining", 128'(in_ready), 128'd1);
        in_a = gen_op(n, 1); in_b = gen_op(n, 2); in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    chk("R5 stream count", 128'(rcv), 128'd8);

    // stall: R10 R6
    out_ready = 1'b0;
    acc = 0;
    for (int n = 0; n < LAT + 3; n++) begin
      in_a = gen_op(20 + acc, 3); in_b = gen_op(20 + acc, 4); in_valid = 1'b1;
      if (in_ready) acc++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R10 pairs taken while stalled", 128'(acc), 128'(LAT));
    chk("R10 in_ready low when full", 128'(in_ready), 128'd0);
    chk("R6 out_valid during stall", 128'(out_valid), 128'd1);
    held = out_data;
    repeat (3) @(negedge clk);
    chk("R6 out_valid held", 128'(out_valid), 128'd1);
    chk("R6 out_data held", out_data, held);
    chk("R5 first stalled result", held, ref_mul(gen_op(20, 3), gen_op(20, 4)));

    // drain in order
    out_ready = 1'b1;
    for (int n = 0; n < LAT; n++) begin
      chk("R5 drain valid", 128'(out_valid), 128'd1);
      chk("R5 drain order", out_data, ref_mul(gen_op(20 + n, 3), gen_op(20 + n, 4)));
      @(negedge clk);
    end
    chk("R5 drained empty", 128'(out_valid), 128'd0);

    // R9: reset while full
    out_ready = 1'b0;
    for (int n = 0; n < LAT; n++) begin
      in_a = gen_op(40 + n, 5); in_b = gen_op(40 + n, 6); in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R9 full before reset", 128'(in_ready), 128'd0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 out_valid cleared", 128'(out_valid), 128'd0);
    chk("R9 in_ready after reset", 128'(in_ready), 128'd1);
    rst_n = 1'b1;
    repeat (LAT + 1) @(negedge clk);
    chk("R9 stays empty", 128'(out_valid), 128'd0);

    summary();
  end
endmodule